// File: doc/BRIEF.md
# Processor Core Reset Controller with Guarded Writes

This block owns the reset lines and clock enables of two processor cores and exposes one 32-bit control word per core. Every writable bit in a word sits in the low half. A write changes that bit only when a companion enable bit sixteen places higher is also 1 in the same write data. This lets software touch one field without a read-modify-write.

Core 0 uses a held reset. It stays in reset until software releases it. On release, reset drops while its clock stays stopped for a programmed number of 0.25 µs ticks. Then the clock restarts and a sticky done flag is raised. Asserting it again stops the clock for the apply interval, then holds reset with the clock running.

Core 1 uses a self-timed pulse. A single write of 1 runs the whole sequence with no further software action: an apply interval, a remove interval, clock restart and done. Both done flags are write-one-to-clear, guarded by their own enable bit.

Top module: `core_rst_ctl`

## Requirements
- R1: After power-on reset, core 0 reads control word 0x0000_0001 (reset requested, done clear) with `core_rst[0]`=1 and `core_clk_en[0]`=1. Core 1 reads 0x0000_0000 with `core_rst[1]`=0 and `core_clk_en[1]`=1.
- R2: Control bit 0 of a word is updated from write data bit 0 only when write data bit 16 is 1. Otherwise it keeps its value.
- R3: Read data carries the control bit in bit 0 and the done flag in bit 12. All other bits, the enable positions 16 and 28 included, read 0.
- R4: Writing core 0 bit 0 to 0 (with bit 16) drops `core_rst[0]` and `core_clk_en[0]` one cycle after the write edge. The clock stays stopped for REMOVE_TICKS×TICK_DIV cycles. In the following cycle the clock enable returns to 1 and done (bit 12) reads 1.
- R5: Writing core 0 bit 0 to 1 (with bit 16) raises `core_rst[0]` and drops `core_clk_en[0]` one cycle after the write edge. After APPLY_TICKS×TICK_DIV cycles the clock resumes while reset stays high.
- R6: Writing core 1 bit 0 to 1 (with bit 16) raises `core_rst[1]` with the clock stopped for APPLY_TICKS×TICK_DIV cycles. Reset then drops with the clock still stopped for REMOVE_TICKS×TICK_DIV cycles. After that the clock resumes, bit 0 reads 0 again and done reads 1.
- R7: A done flag clears only on a write with both bit 12 and bit 28 set. A 1 in bit 12 alone leaves it set.
- R8: During a core 1 sequence, writes to its control bit (0 or 1) have no effect on the sequence or its timing.
- R9: A done flag is never raised while the matching core reset is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Written word: 0 core 0, 1 core 1 |
| wdata | input | 32 | Write data with enables in bits 31:16 |
| rd_sel | input | 1 | Read word: 0 core 0, 1 core 1 |
| rdata | output | 32 | Combinational read of the selected word |
| core_rst | output | 2 | Active-high core resets |
| core_clk_en | output | 2 | Core clock enables, 0 while stopped |

## Verification
A write lands in the control bit at its own clock edge, so read data shows it in the next sample. Reset and clock-enable outputs move one edge later, and each timed interval lasts exactly ticks × TICK_DIV cycles after that. The bench drives inputs and samples at falling edges and counts edges from each write. It checks the last cycle of every interval and the first cycle after it, for release, assertion and the self-timed pulse. The table-driven checks wait well past every sequence before reading back.

// File: rtl/core_rst_ctl.sv
module core_rst_ctl #(
  parameter int TICK_DIV     = 32,
  parameter int APPLY_TICKS  = 15,
  parameter int REMOVE_TICKS = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wdata,
  input  logic        rd_sel,
  output logic [31:0] rdata,
  output logic [1:0]  core_rst,
  output logic [1:0]  core_clk_en
);
  localparam int CTL   = 0;
  localparam int DONE  = 12;
  localparam int WEOFS = 16;
  localparam int LEN_A = (APPLY_TICKS * TICK_DIV < 1) ? 1 : APPLY_TICKS * TICK_DIV;
  localparam int LEN_R = (REMOVE_TICKS * TICK_DIV < 1) ? 1 : REMOVE_TICKS * TICK_DIV;
  localparam int LEN_M = (LEN_A > LEN_R) ? LEN_A : LEN_R;
  localparam int CW    = $clog2(LEN_M + 1);

  typedef enum logic [1:0] {S_RUN, S_APPLY, S_HELD, S_REMOVE} st_t;

  logic [1:0] ctrl, done, fin, wsel;
  logic       ctl_we, done_clr;
  logic       unused_wbits;

  assign wsel         = wr_en ? (wr_sel ? 2'b10 : 2'b01) : 2'b00;
  assign ctl_we       = wdata[CTL + WEOFS];
  assign done_clr     = wdata[DONE + WEOFS] & wdata[DONE];
  assign unused_wbits = ^{wdata[31:29], wdata[27:17], wdata[15:13], wdata[11:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= 2'b01;
      done <= 2'b00;
    end else begin
      if (wsel[0] && ctl_we) ctrl[0] <= wdata[CTL];
      if (fin[1]) ctrl[1] <= 1'b0;
      else if (wsel[1] && ctl_we && wdata[CTL] && !ctrl[1]) ctrl[1] <= 1'b1;
      for (int i = 0; i < 2; i++) begin
        if (fin[i]) done[i] <= 1'b1;
        else if (wsel[i] && done_clr) done[i] <= 1'b0;
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    st_t           st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= (ch == 0) ? S_HELD : S_RUN;
        cnt <= '0;
      end else begin
        unique case (st)
          S_RUN: if (ctrl[ch]) begin
            st  <= S_APPLY;
            cnt <= CW'(LEN_A - 1);
          end
          S_APPLY: if (cnt == '0) begin
            if (ch == 0) st <= S_HELD;
            else begin
              st  <= S_REMOVE;
              cnt <= CW'(LEN_R - 1);
            end
          end else cnt <= cnt - 1'b1;
          S_HELD: if (!ctrl[ch]) begin
            st  <= S_REMOVE;
            cnt <= CW'(LEN_R - 1);
          end
          S_REMOVE: if (cnt == '0) st <= S_RUN;
                    else cnt <= cnt - 1'b1;
          default: st <= S_RUN;
        endcase
      end
    end

    assign fin[ch]         = (st == S_REMOVE) && (cnt == '0);
    assign core_rst[ch]    = (st == S_APPLY) || (st == S_HELD);
    assign core_clk_en[ch] = !((st == S_APPLY) || (st == S_REMOVE));

    a_r9_done_only_released: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[ch]) |-> !core_rst[ch]);
  end

  assign rdata = {19'b0, done[rd_sel], 11'b0, ctrl[rd_sel]};

  a_r2_ctl_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel && wdata[16]) |=> $stable(ctrl[0]));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done[0] && !(wr_en && !wr_sel && wdata[28] && wdata[12])) |=> done[0]);
  a_r4_release_clock_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst[0]) |-> !core_clk_en[0]);
  a_r5_apply_clock_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst[0]) |-> !core_clk_en[0]);
  a_r6_self_clear_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl[1]) |-> done[1]);
endmodule

// File: tb/tb_core_rst_ctl.sv
module tb_core_rst_ctl;
  localparam int TD = 2, AT = 3, RT = 2;
  localparam int LA = AT * TD, LR = RT * TD;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  core_rst, core_clk_en;
  int nvec = 0, nerr = 0;
  bit finished = 1'b0;

  core_rst_ctl #(.TICK_DIV(TD), .APPLY_TICKS(AT), .REMOVE_TICKS(RT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wdata(wdata),
    .rd_sel(rd_sel), .rdata(rdata), .core_rst(core_rst), .core_clk_en(core_clk_en));

  always #4 clk = ~clk;

  // sel, wdata, expected rdata, expected core_rst, expected core_clk_en
  localparam int NV = 10;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 32'h0000_0001, 2'b01, 2'b11},  // R2 no enable
    {1'b0, 32'h0001_0000, 32'h0000_1000, 2'b00, 2'b11},  // R4 release
    {1'b0, 32'h0000_1000, 32'h0000_1000, 2'b00, 2'b11},  // R7 no clear enable
    {1'b0, 32'h1000_1000, 32'h0000_0000, 2'b00, 2'b11},  // R7 clear
    {1'b0, 32'h0001_0001, 32'h0000_0001, 2'b01, 2'b11},  // R5 held
    {1'b0, 32'h0001_0000, 32'h0000_1000, 2'b00, 2'b11},  // R4 release
    {1'b1, 32'h0000_0001, 32'h0000_0000, 2'b00, 2'b11},  // R2 core 1 no enable
    {1'b1, 32'h0001_0001, 32'h0000_1000, 2'b00, 2'b11},  // R6 pulse done
    {1'b1, 32'h1000_1000, 32'h0000_0000, 2'b00, 2'b11},  // R7 clear core 1
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 2'b01, 2'b11}   // R3 enables read 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    rd_sel = 1'b0;
    #1;
    chk("R1 core0 word", rdata, 32'h1);
    chk("R1 resets", {30'b0, core_rst}, 32'h1);
    chk("R1 clock enables", {30'b0, core_clk_en}, 32'h3);
    rd_sel = 1'b1; #1;
    chk("R1 core1 word", rdata, 32'h0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][68], VEC[i][67:36]);
      cyc(20);
      rd_sel = VEC[i][68]; #1;
      chk($sformatf("vector %0d word", i), rdata, VEC[i][35:4]);
      chk($sformatf("vector %0d resets", i), {30'b0, core_rst}, {30'b0, VEC[i][3:2]});
      chk($sformatf("vector %0d clock enables", i), {30'b0, core_clk_en}, {30'b0, VEC[i][1:0]});
      @(negedge clk);
    end

    // R4 release timing
    rd_sel = 1'b0;
    wr(1'b0, 32'h0001_0000);
    cyc(1);
    chk("R4 reset dropped", {31'b0, core_rst[0]}, 32'h0);
    chk("R4 clock stopped", {31'b0, core_clk_en[0]}, 32'h0);
    cyc(LR - 1);
    chk("R4 clock still stopped at last remove cycle", {31'b0, core_clk_en[0]}, 32'h0);
    chk("R4 done not yet set", rdata, 32'h0);
    cyc(1);
    chk("R4 clock restarted", {31'b0, core_clk_en[0]}, 32'h1);
    chk("R4 done set", rdata, 32'h0000_1000);

    // R5 assert timing
    wr(1'b0, 32'h1001_1001);
    chk("R5 control bit and done clear at write edge", rdata, 32'h1);
    cyc(1);
    chk("R5 reset raised", {31'b0, core_rst[0]}, 32'h1);
    chk("R5 clock stopped", {31'b0, core_clk_en[0]}, 32'h0);
    cyc(LA - 1);
    chk("R5 clock stopped at last apply cycle", {31'b0, core_clk_en[0]}, 32'h0);
    cyc(1);
    chk("R5 clock resumed in reset", {30'b0, core_clk_en[0], core_rst[0]}, 32'h3);
    chk("R9 done stays clear while held", rdata, 32'h1);

    // R6 and R8 self-timed pulse with ignored writes
    rd_sel = 1'b1;
    wr(1'b1, 32'h0001_0001);
    chk("R6 control bit reads 1 during pulse", rdata, 32'h1);
    cyc(1);
    chk("R6 reset raised", {31'b0, core_rst[1]}, 32'h1);
    chk("R6 clock stopped", {31'b0, core_clk_en[1]}, 32'h0);
    wr(1'b1, 32'h0001_0000);
    chk("R8 write 0 ignored", rdata, 32'h1);
    cyc(LA - 2);
    chk("R8 reset still high at last apply cycle", {31'b0, core_rst[1]}, 32'h1);
    wr(1'b1, 32'h0001_0001);
    chk("R6 reset dropped", {31'b0, core_rst[1]}, 32'h0);
    chk("R6 clock stopped in remove", {31'b0, core_clk_en[1]}, 32'h0);
    cyc(LR - 1);
    chk("R6 clock stopped at last remove cycle", {31'b0, core_clk_en[1]}, 32'h0);
    chk("R8 no restart", {31'b0, core_rst[1]}, 32'h0);
    cyc(1);
    chk("R6 clock resumed", {31'b0, core_clk_en[1]}, 32'h1);
    chk("R6 self cleared with done", rdata, 32'h0000_1000);
    cyc(LA + LR + 4);
    chk("R8 no second pulse", {30'b0, core_rst[1], core_clk_en[1]}, 32'h1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule